// File: doc/BRIEF.md
# Serial Audio Transmitter

This block turns a stream of 32-bit audio samples into a synchronous serial link: a bit clock, a frame sync and one data line. Samples arrive on a valid/ready stream into a sample FIFO. A sample is taken when `samp_valid` and `samp_ready` are both high on a rising clock edge. The block drops `samp_ready` only while the FIFO is full. The source may hold `samp_valid` for any length of time, and a held sample is taken as soon as space frees up.

Software programs the block through a small 32-bit register bus. A control word starts and stops transmission, enables the bit clock and selects the DMA request and error interrupt. The remaining registers set the bit clock divider and polarity, the frame shape, the word widths, the first data bit and its direction, the sync width, early sync, sync polarity, and the FIFO watermark. The frame shape is built entirely from these fields; no audio format is wired in. The core clock acts as the master clock. When the transmitter is stopped, it completes the frame in progress and then returns its pins to their idle levels.

Top module: `sat_tx`

## Requirements
- R1: After reset, `bclk`, `fsync`, `sdata`, `dma_req` and `irq` are low, `samp_ready` is high, and every register reads zero.
- R2: Each serial bit lasts 2*(div+1) core clocks, where div is CLKCFG[7:0] at offset 0x08. CLKCFG[25] inverts the bit clock and sets its idle level. Data and sync change at the start of a bit, and the bit clock moves away from its idle level half a bit later.
- R3: A frame holds FRAME[20:16]+1 words, with FRAME at offset 0x10. Word 0 is WORD[20:16]+1 bits long and every later word is WORD[28:24]+1 bits long, with WORD at offset 0x14. Frames follow each other with no gap.
- R4: Each word starts with sample bit WORD[12:8]. The bit index then falls by one per bit when FRAME[4] is set, and rises by one per bit when FRAME[4] is clear. The index wraps modulo 32.
- R5: Frame sync is active for the first FRAME[12:8]+1 bits of a frame. When FRAME[3] is set, the window starts one bit earlier, on the last bit of the previous frame. In that case the first frame after a start shows only FRAME[12:8] active bits. FRAME[1] makes the sync active-low.
- R6: While CLKCFG[24] is clear, `bclk` is held at its idle level. While FRAME[0] is clear, `fsync` is held inactive. Shifting continues in both cases.
- R7: While CHAN[16] (offset 0x0C) is clear, `sdata` stays low, but words are still taken from the FIFO.
- R8: The FIFO holds 32 samples. `samp_ready` is low exactly when the FIFO is full.
- R9: `dma_req` is high when CTRL[0] (offset 0x00) is set and the FIFO count is at or below WMARK (offset 0x04).
- R10: If a word starts while the FIFO is empty, zeros are sent for that word and the sticky flag CTRL[18] is set. Writing 1 to CTRL[18] clears the flag. `irq` equals CTRL[18] AND CTRL[10].
- R11: Writes to offsets 0x04 to 0x14 are ignored while CTRL[31] is set or a frame is still finishing. CTRL itself is always writable and readable.
- R12: Transmission starts when both CTRL[31] and CTRL[28] are set. Clearing either bit lets the current frame finish, after which all pins return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| samp_valid | input | 1 | Sample stream valid |
| samp_ready | output | 1 | Sample stream ready |
| samp_data | input | 32 | Sample stream data |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| dma_req | output | 1 | FIFO refill request |
| irq | output | 1 | FIFO underrun interrupt |

## Verification
The bench builds the block with its default parameters: a 32-entry FIFO and an 8-bit divider field. With these values, 32 pushes are enough to reach the full condition and the watermark boundary. The bench programs divider values of 0 and 1 so that every frame is only a few dozen core clocks long. At that length, complete two-frame streams are captured bit by bit at the sampling edge of the bit clock. These short streams cover a stop requested in the middle of a frame, early sync across a frame boundary, and an underrun on the last word.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned FLD_W    = 5;
  localparam int unsigned SAMPLE_W = 1 << FLD_W;
  localparam int unsigned DIV_W    = 8;

  localparam logic [REG_AW-1:0] A_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] A_WMARK = 5'h04;
  localparam logic [REG_AW-1:0] A_CLK   = 5'h08;
  localparam logic [REG_AW-1:0] A_CHAN  = 5'h0C;
  localparam logic [REG_AW-1:0] A_FRAME = 5'h10;
  localparam logic [REG_AW-1:0] A_WORD  = 5'h14;

  localparam int B_TE  = 31;
  localparam int B_BCE = 28;
  localparam int B_ERR = 18;
  localparam int B_IE  = 10;
  localparam int B_DMA = 0;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             bclk_pol;
    logic             bclk_dir;
    logic             chan_en;
    logic [FLD_W-1:0] fsz;
    logic [FLD_W-1:0] syw;
    logic             msb_first;
    logic             early;
    logic             fs_low;
    logic             fs_dir;
    logic [FLD_W-1:0] w0;
    logic [FLD_W-1:0] wn;
    logic [FLD_W-1:0] fbt;
  } cfg_t;
endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/sat_regs.sv
module sat_regs import sat_pkg::*; #(
  parameter int unsigned CW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              err_set,
  output cfg_t              cfg,
  output logic [CW-1:0]     wmark,
  output logic              tx_en,
  output logic              bclk_en,
  output logic              dma_en,
  output logic              err_ie,
  output logic              err_flag
);
  logic ctrl_wr, cfg_wr, unused_wdata;

  assign ctrl_wr      = reg_we && (reg_addr == A_CTRL);
  assign cfg_wr       = reg_we && !busy;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      bclk_en  <= 1'b0;
      dma_en   <= 1'b0;
      err_ie   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        tx_en   <= reg_wdata[B_TE];
        bclk_en <= reg_wdata[B_BCE];
        dma_en  <= reg_wdata[B_DMA];
        err_ie  <= reg_wdata[B_IE];
      end
      if (err_set)                           err_flag <= 1'b1;
      else if (ctrl_wr && reg_wdata[B_ERR])  err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      wmark <= '0;
    end else if (cfg_wr) begin
      case (reg_addr)
        A_WMARK: wmark <= reg_wdata[CW-1:0];
        A_CLK: begin
          cfg.div      <= reg_wdata[DIV_W-1:0];
          cfg.bclk_dir <= reg_wdata[24];
          cfg.bclk_pol <= reg_wdata[25];
        end
        A_CHAN: cfg.chan_en <= reg_wdata[16];
        A_FRAME: begin
          cfg.fsz       <= reg_wdata[20:16];
          cfg.syw       <= reg_wdata[12:8];
          cfg.msb_first <= reg_wdata[4];
          cfg.early     <= reg_wdata[3];
          cfg.fs_low    <= reg_wdata[1];
          cfg.fs_dir    <= reg_wdata[0];
        end
        A_WORD: begin
          cfg.wn  <= reg_wdata[28:24];
          cfg.w0  <= reg_wdata[20:16];
          cfg.fbt <= reg_wdata[12:8];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_TE]  = tx_en;
        reg_rdata[B_BCE] = bclk_en;
        reg_rdata[B_ERR] = err_flag;
        reg_rdata[B_IE]  = err_ie;
        reg_rdata[B_DMA] = dma_en;
      end
      A_WMARK: reg_rdata[CW-1:0] = wmark;
      A_CLK: begin
        reg_rdata[DIV_W-1:0] = cfg.div;
        reg_rdata[24]        = cfg.bclk_dir;
        reg_rdata[25]        = cfg.bclk_pol;
      end
      A_CHAN: reg_rdata[16] = cfg.chan_en;
      A_FRAME: begin
        reg_rdata[20:16] = cfg.fsz;
        reg_rdata[12:8]  = cfg.syw;
        reg_rdata[4]     = cfg.msb_first;
        reg_rdata[3]     = cfg.early;
        reg_rdata[1]     = cfg.fs_low;
        reg_rdata[0]     = cfg.fs_dir;
      end
      A_WORD: begin
        reg_rdata[28:24] = cfg.wn;
        reg_rdata[20:16] = cfg.w0;
        reg_rdata[12:8]  = cfg.fbt;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R11: configuration cannot move while the transmitter is busy
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg) && $stable(wmark)));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(ctrl_wr && reg_wdata[B_ERR])) |=> err_flag);
endmodule

// File: rtl/sat_bclk.sv
module sat_bclk #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          ph,
  output logic          adv
);
  logic [DW-1:0] cnt;

  assign adv = run && ph && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == div) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= div);
  a_r2_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ph == 1'b0));
endmodule

// File: rtl/sat_framer.sv
module sat_framer import sat_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  cfg_t                cfg,
  input  logic                adv,
  input  logic                fifo_valid,
  input  logic [SAMPLE_W-1:0] fifo_data,
  output logic                pop,
  output logic                err_set,
  output logic                running,
  output logic                sdata,
  output logic                fs_act
);
  localparam int unsigned IW  = FLD_W;
  localparam int unsigned LW  = IW + 1;
  localparam int unsigned FLW = 2 * IW + 1;

  logic [FLW-1:0]      fbit, fbit_nx, frame_len;
  logic [LW-1:0]       kbit, wlen0, wlen_n, cur_wlen;
  logic [IW-1:0]       widx, sel;
  logic [SAMPLE_W-1:0] word_q, ld_word;
  logic start, step, last_w, last_f, stop, load, fs_nx, unused_cfg;

  assign unused_cfg = ^cfg;
  assign wlen0     = {1'b0, cfg.w0} + LW'(1);
  assign wlen_n    = {1'b0, cfg.wn} + LW'(1);
  assign frame_len = FLW'(wlen0) + FLW'(cfg.fsz) * FLW'(wlen_n);
  assign cur_wlen  = (widx == '0) ? wlen0 : wlen_n;

  assign start  = go && !running;
  assign step   = running && adv;
  assign last_w = (kbit == cur_wlen - LW'(1));
  assign last_f = last_w && (widx == cfg.fsz);
  assign stop   = step && last_f && !go;
  assign load   = start || (step && last_w && !stop);

  assign pop     = load && fifo_valid;
  assign err_set = load && !fifo_valid;
  assign ld_word = fifo_valid ? fifo_data : '0;

  assign fbit_nx = (start || last_f) ? '0 : fbit + 1'b1;
  assign fs_nx   = cfg.early
                 ? ((fbit_nx < FLW'(cfg.syw)) || (go && (fbit_nx == frame_len - FLW'(1))))
                 : (fbit_nx <= FLW'(cfg.syw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      fs_act  <= 1'b0;
      fbit    <= '0;
      kbit    <= '0;
      widx    <= '0;
      word_q  <= '0;
    end else if (start) begin
      running <= 1'b1;
      fs_act  <= fs_nx;
      fbit    <= '0;
      kbit    <= '0;
      widx    <= '0;
      word_q  <= ld_word;
    end else if (stop) begin
      running <= 1'b0;
      fs_act  <= 1'b0;
    end else if (step) begin
      fbit   <= fbit_nx;
      fs_act <= fs_nx;
      if (last_f) begin
        kbit   <= '0;
        widx   <= '0;
        word_q <= ld_word;
      end else if (last_w) begin
        kbit   <= '0;
        widx   <= widx + 1'b1;
        word_q <= ld_word;
      end else begin
        kbit <= kbit + 1'b1;
      end
    end
  end

  assign sel   = cfg.msb_first ? (cfg.fbt - kbit[IW-1:0]) : (cfg.fbt + kbit[IW-1:0]);
  assign sdata = running && cfg.chan_en && word_q[sel];

  a_r3_bit_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> kbit < cur_wlen);
  a_r12_sync_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !fs_act);
  a_r12_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(running)) |-> ($past(fbit) == $past(frame_len) - FLW'(1)));
endmodule

// File: rtl/sat_tx.sv
module sat_tx import sat_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                samp_valid,
  output logic                samp_ready,
  input  logic [SAMPLE_W-1:0] samp_data,
  output logic                bclk,
  output logic                fsync,
  output logic                sdata,
  output logic                dma_req,
  output logic                irq
);
  cfg_t                cfg;
  logic [CW-1:0]       wmark, count;
  logic                tx_en, bclk_en, dma_en, err_ie, err_flag;
  logic                running, err_set, pop, fifo_valid, ph, adv, fs_act;
  logic [SAMPLE_W-1:0] fifo_data;

  sat_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(tx_en || running),
    .err_set(err_set), .cfg(cfg), .wmark(wmark), .tx_en(tx_en),
    .bclk_en(bclk_en), .dma_en(dma_en), .err_ie(err_ie), .err_flag(err_flag)
  );

  sat_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(samp_valid), .in_ready(samp_ready),
    .in_data(samp_data), .pop(pop), .out_valid(fifo_valid),
    .out_data(fifo_data), .count(count)
  );

  sat_bclk #(.DW(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(running), .div(cfg.div), .ph(ph), .adv(adv)
  );

  sat_framer u_framer (
    .clk(clk), .rst_n(rst_n), .go(tx_en && bclk_en), .cfg(cfg), .adv(adv),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .pop(pop),
    .err_set(err_set), .running(running), .sdata(sdata), .fs_act(fs_act)
  );

  assign bclk    = (running && cfg.bclk_dir) ? (ph ^ cfg.bclk_pol) : cfg.bclk_pol;
  assign fsync   = (fs_act && cfg.fs_dir) ^ cfg.fs_low;
  assign dma_req = dma_en && (count <= wmark);
  assign irq     = err_ie && err_flag;

  a_r9_dma_level: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !samp_valid && !pop) |=> (dma_req || !dma_en || $changed(wmark)));
  a_r8_ready_when_draining: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> samp_ready);
endmodule

// File: tb/sat_tx_tb_top.sv
module sat_tx_tb_top;
  localparam logic [4:0] CTRL = 5'h00, WMARK = 5'h04, CLKC = 5'h08,
                         CHAN = 5'h0C, FRAME = 5'h10, WORD = 5'h14;
  localparam logic [31:0] TE = 32'h8000_0000, BCE = 32'h1000_0000,
                          ERRB = 32'h0004_0000, IE = 32'h0000_0400, DMA = 32'h1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, reg_we = 1'b0, samp_valid = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, samp_data = '0, reg_rdata;
  logic samp_ready, bclk, fsync, sdata, dma_req, irq;

  sat_tx dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .samp_valid(samp_valid),
    .samp_ready(samp_ready), .samp_data(samp_data), .bclk(bclk),
    .fsync(fsync), .sdata(sdata), .dma_req(dma_req), .irq(irq)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bit capture at the sampling edge of the bit clock
  logic cap_on = 0, cap_pol = 0, prev_b = 0;
  int   cap_n = 0;
  logic cap_d [256];
  logic cap_f [256];
  int   cap_t [256];
  always @(negedge clk) begin
    if (cap_on && prev_b == cap_pol && bclk != cap_pol && cap_n < 256) begin
      cap_d[cap_n] = sdata;
      cap_f[cap_n] = fsync;
      cap_t[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
    prev_b = bclk;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    logic acc;
    @(negedge clk); samp_valid = 1'b1; samp_data = d;
    forever begin
      acc = samp_ready;
      @(negedge clk);
      if (acc) break;
    end
    samp_valid = 1'b0;
  endtask

  task automatic do_reset();
    cap_on = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_cap(input logic pol);
    cap_n = 0; cap_pol = pol; prev_b = bclk; cap_on = 1;
  endtask

  function automatic logic [31:0] clk_w(input bit dir, input bit pol, input int dv);
    return (32'(dir) << 24) | (32'(pol) << 25) | 32'(dv);
  endfunction
  function automatic logic [31:0] frm_w(input int fsz, input int syw, input bit msb,
                                        input bit early, input bit low, input bit dir);
    return (32'(fsz) << 16) | (32'(syw) << 8) | (32'(msb) << 4) | (32'(early) << 3)
         | (32'(low) << 1) | 32'(dir);
  endfunction
  function automatic logic [31:0] wrd_w(input int wn, input int w0, input int fbt);
    return (32'(wn) << 24) | (32'(w0) << 16) | (32'(fbt) << 8);
  endfunction

  // R1: reset state
  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "bclk", bclk, 0);
    chk("R1", "fsync", fsync, 0);
    chk("R1", "sdata", sdata, 0);
    chk("R1", "dma_req", dma_req, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "samp_ready", samp_ready, 1);
    rd(CTRL, v);  chk("R1", "ctrl", v, 0);
    rd(WORD, v);  chk("R1", "word", v, 0);
    rd(FRAME, v); chk("R1", "frame", v, 0);
  endtask

  // R2 R3 R4 R5 R11 R12: two-word MSB-first frames, stop mid-frame
  task automatic t_msb_stereo();
    logic [31:0] s [4] = '{32'hDEAD_BEEF, 32'h1234_5678, 32'hF00D_CAFE, 32'h8001_7FFE};
    logic [31:0] v;
    int bad_d = 0, bad_f = 0;
    do_reset();
    wr(CLKC, clk_w(1, 0, 1));
    wr(FRAME, frm_w(1, 15, 1, 0, 0, 1));
    wr(WORD, wrd_w(15, 15, 31));
    wr(CHAN, 32'h0001_0000);
    for (int i = 0; i < 4; i++) push(s[i]);
    start_cap(0);
    wr(CTRL, TE | BCE);
    while (cap_n < 40) @(negedge clk);
    wr(CTRL, 32'h0);
    wr(WORD, wrd_w(3, 3, 3));           // R11: frame still finishing
    rd(WORD, v); chk("R11", "word write during finishing frame", v, wrd_w(15, 15, 31));
    repeat (300) @(negedge clk);
    chk("R12", "bits sent after stop", cap_n, 64);
    for (int p = 0; p < 64; p++) begin
      int f = p / 32, q = p % 32, w = q / 16, k = q % 16;
      logic eb = s[2 * f + w][(31 - k) & 31];
      if (cap_d[p] !== eb) bad_d++;
      if (cap_f[p] !== (q < 16)) bad_f++;
    end
    chk("R4", "msb-first data mismatches", bad_d, 0);
    chk("R5", "sync window mismatches", bad_f, 0);
    chk("R2", "bit period div=1", cap_t[1] - cap_t[0], 4);
    chk("R3", "frame boundary period", cap_t[32] - cap_t[31], 4);
    chk("R12", "bclk idle after stop", bclk, 0);
    chk("R12", "fsync idle after stop", fsync, 0);
  endtask

  // R2 R3 R4 R5 R10: three words, LSB-first, early active-low sync, inverted clock, underrun
  task automatic t_lsb_early();
    logic [31:0] s [6] = '{32'h0000_F0F0, 32'h0000_0AA5, 32'h0000_0F3C,
                           32'h0000_1234, 32'h0000_FFF0, 32'h0};
    logic [31:0] v;
    int bad_d = 0, bad_f = 0;
    do_reset();
    wr(CLKC, clk_w(1, 1, 0));
    wr(FRAME, frm_w(2, 3, 0, 1, 1, 1));
    wr(WORD, wrd_w(7, 11, 4));
    wr(CHAN, 32'h0001_0000);
    for (int i = 0; i < 5; i++) push(s[i]);   // sixth word underruns
    chk("R5", "active-low idle level", fsync, 1);
    chk("R2", "inverted idle level", bclk, 1);
    start_cap(1);
    wr(CTRL, TE | BCE);
    while (cap_n < 35) @(negedge clk);
    wr(CTRL, 32'h0);
    repeat (150) @(negedge clk);
    chk("R3", "bits in two 28-bit frames", cap_n, 56);
    for (int p = 0; p < 56; p++) begin
      int f = p / 28, q = p % 28, w, k;
      logic act;
      if (q < 12) begin w = 0; k = q; end
      else begin w = 1 + (q - 12) / 8; k = (q - 12) % 8; end
      if (cap_d[p] !== s[3 * f + w][(4 + k) & 31]) bad_d++;
      act = (q < 3) || (q == 27 && f == 0);
      if (cap_f[p] !== !act) bad_f++;
    end
    chk("R4", "lsb-first data mismatches (R10 zero word)", bad_d, 0);
    chk("R5", "early sync mismatches", bad_f, 0);
    chk("R2", "bit period div=0", cap_t[1] - cap_t[0], 2);
    rd(CTRL, v); chk("R10", "underrun flag", v[18], 1);
    chk("R10", "irq masked without enable", irq, 0);
  endtask

  // R6 R7 R9 R10: channel off, sync output off, underrun interrupt
  task automatic t_chan_off();
    logic [31:0] v;
    int ones = 0, fs_hi = 0;
    do_reset();
    wr(CLKC, clk_w(1, 0, 0));
    wr(FRAME, frm_w(1, 0, 1, 0, 0, 0));
    wr(WORD, wrd_w(7, 7, 7));
    wr(WMARK, 32'h0);
    wr(CTRL, IE | DMA);
    push(32'h0000_00FF);
    chk("R9", "dma_req with count above watermark", dma_req, 0);
    start_cap(0);
    wr(CTRL, TE | BCE | IE | DMA);
    while (cap_n < 4) @(negedge clk);
    wr(CTRL, IE | DMA);
    repeat (100) @(negedge clk);
    chk("R12", "bits in one frame", cap_n, 16);
    for (int p = 0; p < 16; p++) begin
      if (cap_d[p] !== 1'b0) ones++;
      if (cap_f[p] !== 1'b0) fs_hi++;
    end
    chk("R7", "sdata high while channel off", ones, 0);
    chk("R6", "fsync active while direction off", fs_hi, 0);
    chk("R7", "word consumed (dma_req at empty)", dma_req, 1);
    rd(CTRL, v); chk("R10", "underrun flag set", v[18], 1);
    chk("R10", "irq with enable", irq, 1);
    wr(CTRL, IE | DMA | ERRB);
    rd(CTRL, v); chk("R10", "flag cleared by write-one", v[18], 0);
    chk("R10", "irq after clear", irq, 0);
  endtask

  // R8 R9 R11: watermark, full FIFO, configuration lock
  task automatic t_fifo_regs();
    logic [31:0] v;
    do_reset();
    wr(WMARK, 32'd2);
    wr(CTRL, DMA);
    chk("R9", "dma_req empty", dma_req, 1);
    push(32'h1); push(32'h2);
    chk("R9", "dma_req at watermark", dma_req, 1);
    push(32'h3);
    chk("R9", "dma_req above watermark", dma_req, 0);
    for (int i = 3; i < 32; i++) begin
      chk("R8", "ready below full", samp_ready, 1);
      push(32'(i));
    end
    chk("R8", "ready low when full", samp_ready, 0);
    wr(CTRL, TE);
    rd(CTRL, v); chk("R11", "ctrl readback", v, TE);
    wr(WORD, wrd_w(5, 0, 0));
    rd(WORD, v); chk("R11", "word write while enabled", v, 0);
    wr(CTRL, 32'h0);
    wr(WORD, wrd_w(5, 0, 0));
    rd(WORD, v); chk("R11", "word write while stopped", v, wrd_w(5, 0, 0));
  endtask

  // R6: bit clock output disabled while shifting continues
  task automatic t_bclk_off();
    int edges = 0, fs_seen = 0;
    logic pb;
    do_reset();
    wr(CLKC, clk_w(0, 0, 0));
    wr(FRAME, frm_w(0, 0, 1, 0, 0, 1));
    wr(WORD, wrd_w(3, 3, 31));
    wr(WMARK, 32'h0);
    wr(CTRL, DMA);
    push(32'hFFFF_FFFF); push(32'h0);
    chk("R9", "dma_req with two queued", dma_req, 0);
    wr(CTRL, TE | BCE | DMA);
    pb = bclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk != pb) edges++;
      if (fsync) fs_seen = 1;
      pb = bclk;
    end
    chk("R6", "bclk edges with direction off", edges, 0);
    chk("R6", "fsync still generated", fs_seen, 1);
    chk("R6", "words consumed", dma_req, 1);
    wr(CTRL, DMA);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_msb_stereo();
    t_lsb_early();
    t_chan_off();
    t_fifo_regs();
    t_bclk_off();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule